// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is a single-master I2C engine. Software moves it one byte at a time through four word registers: a control register, a status register, a data register and a live line monitor. To send a byte, software loads the data register. It then writes the control register with the transfer-byte command and with any of three per-byte qualifiers: generate START first, generate STOP afterwards, or answer a received byte with NAK. The transfer-byte bit reads back as 1 while the byte is in flight and clears by itself when the byte completes.

The engine drives SCL and SDA only by pulling them low through two open-drain enables. It reads the real line levels back. Its timing comes from a quarter-period divider. The first byte after a START is always the address byte, and its bit 0 selects the direction of the bytes that follow. Between bytes of a transaction the engine holds SCL low, so software can take its time. Outcomes appear as sticky status flags, cleared by writing 1. Five of these flags can raise the interrupt output when their enables are set.

Top module: `i2c_byte_master`

## Requirements
- R1: Register select: 0 = control, 1 = status, 2 = data, 3 = monitor. After reset, control and status read 0 while both lines are high, both open-drain enables are 0 and irq is 0.
- R2: Writing control with bit 3 (transfer-byte) and bit 0 (START) generates a START, then shifts the data register out MSB first as the address byte. Control bit 3 reads 1 until the byte ends and then 0. Afterwards SCL stays held low, and status bit 15 (unit busy) and bit 16 (bus busy) read 1.
- R3: After the acknowledge slot of a written byte, status bit 19 (transmit empty) is set and status bit 14 holds the received acknowledge level (0 = ACK).
- R4: Control bit 1 (STOP) given with transfer-byte appends a STOP condition. Status bit 27 (done) is then set, and status bits 15 and 16 read 0.
- R5: Status bits 14, 18, 19, 20, 22, 26 and 27 are cleared by writing 1 to them. irq is high exactly while a flag is set whose enable is set: bit 18 by control bit 18, bit 19 by 19, bit 20 by 20, bit 22 by 22, and bit 26 by control bit 25.
- R6: After an address byte with bit 0 = 1, each transfer-byte command clocks 8 bits in, MSB first, into the data register and sets status bit 20. In the acknowledge slot the engine drives ACK when control bit 2 is 0 and NAK when it is 1.
- R7: A NAK received on a written byte sets status bits 22 and 14, and the engine then generates a STOP.
- R8: Status bit 26 (master stop) is set at the end of a STOP only when control bit 26 is 1.
- R9: A byte with START and without STOP lasts 40 quarter periods, and one with both START and STOP lasts 44. A quarter period is QTR_STD clocks, or QTR_FAST clocks when control bit 8 is 1.
- R10: If a bit the engine released is sampled low, it sets status bit 18, releases both lines and clears the transfer-byte bit.
- R11: Writing control with bit 10 returns the control register, the status flags and the engine to their reset values and releases both lines.
- R12: A command is taken only if control bits 14 and 13 are 1 in the same write; otherwise the transfer-byte bit stays 0 and the lines stay released. A transfer-byte command without START while the bus is not held is refused: it sets status bit 22 and the transfer-byte bit stays 0.
- R13: Monitor bit 0 shows the live SDA level and bit 1 the live SCL level. Status bit 17 reads 1 while either line is low or the bus is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with QTR_STD = 6 and QTR_FAST = 2, so one byte takes only a few hundred clocks. This puts address, write, read, NAK, arbitration and both speed modes inside one short run, and the exact byte durations remain countable. The bench also contains a behavioural target on the wired-AND bus. The target decodes START, STOP, bits and acknowledge slots on its own, and its observed and served bytes are compared with what the bench commanded.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QTR_STD  = 312,
  parameter int QTR_FAST = 78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam int CW = $clog2(QTR_STD + 1);
  localparam logic [31:0] CTRL_MASK = 32'h065C_6107;

  typedef enum logic [1:0] {S_IDLE, S_START, S_XFER, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] qcnt;
  logic [1:0]  ph;
  logic [3:0]  bitn;
  logic [7:0]  shreg, dbuf;
  logic [31:0] ctrl;
  logic        tb, own, rs, rd, abit, c_start, c_stop, c_nak, smp, ack_rx;
  logic        f_ack, f_ald, f_ite, f_irf, f_bed, f_msd, f_done, ibb;
  logic        scl_d, sda_d;

  wire ctl_wr = reg_wr && reg_sel == 2'd0;
  wire st_wr  = reg_wr && reg_sel == 2'd1;
  wire ur     = ctl_wr && reg_wdata[10];
  wire launch = ctl_wr && !ur && reg_wdata[3] && !tb && reg_wdata[14] && reg_wdata[13];
  wire refuse = launch && !reg_wdata[0] && !own;
  wire [CW-1:0] qlim = ctrl[8] ? CW'(QTR_FAST - 1) : CW'(QTR_STD - 1);
  wire tick   = st != S_IDLE && qcnt == qlim;
  wire endq   = tick && ph == 2'd3;
  wire sample = tick && st == S_XFER && ph == 2'd2;
  wire lost   = sample && !rd && bitn < 4'd8 && shreg[7] && !sda_in;
  wire ub     = own || st != S_IDLE;
  wire ebb    = ibb || !sda_in || !scl_in;

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_IDLE:  scl_oe = own;
      S_START: begin scl_oe = ph == 2'd0 && rs; sda_oe = ph[1]; end
      S_XFER:  begin
        scl_oe = !ph[1];
        sda_oe = bitn == 4'd8 ? (rd && !c_nak) : (!rd && !shreg[7]);
      end
      S_STOP:  begin scl_oe = ph == 2'd0; sda_oe = ph != 2'd3; end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_sel)
      2'd0: reg_rdata = ctrl | {28'd0, tb, 3'd0};
      2'd1: reg_rdata = {4'd0, f_done, f_msd, 3'd0, f_bed, 1'b0, f_irf, f_ite, f_ald,
                         ebb, ibb, ub, f_ack, 14'd0};
      2'd2: reg_rdata = {24'd0, dbuf};
      default: reg_rdata = {30'd0, scl_in, sda_in};
    endcase
  end

  assign irq = (f_ald & ctrl[18]) | (f_ite & ctrl[19]) | (f_irf & ctrl[20]) |
               (f_bed & ctrl[22]) | (f_msd & ctrl[25]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1; ibb <= 1'b0;
    end else begin
      scl_d <= scl_in;
      sda_d <= sda_in;
      if (ur) ibb <= 1'b0;
      else if (scl_d && scl_in && sda_d && !sda_in) ibb <= 1'b1;
      else if (scl_d && scl_in && !sda_d && sda_in) ibb <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qcnt <= '0; ph <= 2'd0; bitn <= 4'd0;
      shreg <= 8'd0; dbuf <= 8'd0; ctrl <= 32'd0;
      tb <= 1'b0; own <= 1'b0; rs <= 1'b0; rd <= 1'b0; abit <= 1'b0;
      c_start <= 1'b0; c_stop <= 1'b0; c_nak <= 1'b0; smp <= 1'b0; ack_rx <= 1'b0;
      f_ack <= 1'b0; f_ald <= 1'b0; f_ite <= 1'b0; f_irf <= 1'b0;
      f_bed <= 1'b0; f_msd <= 1'b0; f_done <= 1'b0;
    end else if (ur) begin
      st <= S_IDLE; qcnt <= '0; ph <= 2'd0; bitn <= 4'd0;
      shreg <= 8'd0; dbuf <= 8'd0; ctrl <= 32'd0;
      tb <= 1'b0; own <= 1'b0; rs <= 1'b0; rd <= 1'b0; abit <= 1'b0;
      c_start <= 1'b0; c_stop <= 1'b0; c_nak <= 1'b0; smp <= 1'b0; ack_rx <= 1'b0;
      f_ack <= 1'b0; f_ald <= 1'b0; f_ite <= 1'b0; f_irf <= 1'b0;
      f_bed <= 1'b0; f_msd <= 1'b0; f_done <= 1'b0;
    end else begin
      if (ctl_wr) ctrl <= reg_wdata & CTRL_MASK;
      if (reg_wr && reg_sel == 2'd2) dbuf <= reg_wdata[7:0];
      if (st_wr) begin
        if (reg_wdata[14]) f_ack  <= 1'b0;
        if (reg_wdata[18]) f_ald  <= 1'b0;
        if (reg_wdata[19]) f_ite  <= 1'b0;
        if (reg_wdata[20]) f_irf  <= 1'b0;
        if (reg_wdata[22]) f_bed  <= 1'b0;
        if (reg_wdata[26]) f_msd  <= 1'b0;
        if (reg_wdata[27]) f_done <= 1'b0;
      end
      if (st != S_IDLE) qcnt <= tick ? '0 : qcnt + 1'b1;
      if (tick) ph <= ph + 2'd1;

      if (refuse) begin
        f_bed <= 1'b1;
      end else if (launch) begin
        tb <= 1'b1; qcnt <= '0; ph <= 2'd0; bitn <= 4'd0; shreg <= dbuf;
        c_start <= reg_wdata[0]; c_stop <= reg_wdata[1]; c_nak <= reg_wdata[2];
        if (reg_wdata[0]) begin
          st <= S_START; rs <= own; own <= 1'b1; rd <= 1'b0; abit <= dbuf[0];
        end else begin
          st <= S_XFER;
        end
      end

      case (st)
        S_START: if (endq) st <= S_XFER;
        S_XFER: begin
          if (sample) smp <= sda_in;
          if (sample && bitn == 4'd8) ack_rx <= sda_in;
          if (lost) begin
            st <= S_IDLE; own <= 1'b0; tb <= 1'b0; f_ald <= 1'b1;
          end else if (endq) begin
            if (bitn < 4'd8) begin
              shreg <= {shreg[6:0], smp};
              bitn  <= bitn + 4'd1;
              if (bitn == 4'd7 && rd) begin
                dbuf <= {shreg[6:0], smp};
                f_irf <= 1'b1;
              end
            end else begin
              bitn <= 4'd0;
              if (c_start) rd <= abit;
              if (!rd) begin f_ack <= ack_rx; f_ite <= 1'b1; end
              if (!rd && ack_rx) begin
                f_bed <= 1'b1; st <= S_STOP;
              end else if (c_stop) begin
                st <= S_STOP;
              end else begin
                st <= S_IDLE; tb <= 1'b0; f_done <= 1'b1;
              end
            end
          end
        end
        S_STOP: if (endq) begin
          st <= S_IDLE; own <= 1'b0; tb <= 1'b0; f_done <= 1'b1;
          if (ctrl[26]) f_msd <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] st,
  input logic       tb,
  input logic       own,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       f_ald,
  input logic       f_msd,
  input logic       f_bed,
  input logic       f_ack,
  input logic       ctrl26
);
  // R2: no SDA change by the engine while SCL stays high inside a byte
  p_sda_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && $past(st) == 2'd2 && scl_in && $past(scl_in)) |-> $stable(sda_oe));

  // R2: without a pending command the engine is idle
  p_tb_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tb |-> st == 2'd0);

  p_nak_bed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ack) |-> f_bed);

  p_msd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_msd) |-> (ctrl26 && !own));

  p_ald_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ald) |-> (!scl_oe && !sda_oe && !tb));
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .tb(tb), .own(own), .scl_in(scl_in),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .f_ald(f_ald), .f_msd(f_msd),
  .f_bed(f_bed), .f_ack(f_ack), .ctrl26(ctrl[26])
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  localparam int QS = 6;
  localparam int QF = 2;
  localparam logic [6:0] TADDR = 7'h50;
  localparam logic [31:0] EN = 32'h0000_6000, TB = 32'h8, STA = 32'h1, STO = 32'h2,
    NAK = 32'h4, FAST = 32'h100, URST = 32'h400, MSDE = 32'h0400_0000,
    MSDIE = 32'h0200_0000, TXIE = 32'h0008_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic t_low = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | t_low);

  i2c_byte_master #(.QTR_STD(QS), .QTR_FAST(QF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl), .sda_in(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  // behavioural target on the wired-AND bus
  bit prv_scl = 1'b1, prv_sda = 1'b1;
  int cnt = 0, starts = 0, stops = 0;
  bit inaddr, sel, trd, wasaddr, force_arb, mack;
  logic [7:0] rx, tx;
  logic [7:0] obs[$];
  logic [7:0] txq[$];
  bit mackq[$];

  always @(negedge clk) begin
    if (prv_scl && scl && prv_sda && !sda) begin
      cnt = 0; inaddr = 1; sel = 0; starts++; t_low = force_arb;
    end else if (prv_scl && scl && !prv_sda && sda) begin
      stops++; sel = 0; t_low = 0;
    end else if (!prv_scl && scl) begin
      if (cnt < 8) rx = {rx[6:0], sda};
      else begin
        mack = sda;
        if (sel && trd && !inaddr) mackq.push_back(sda);
      end
      cnt++;
    end else if (prv_scl && !scl) begin
      if (cnt == 8) begin
        if (inaddr) begin
          sel = rx[7:1] == TADDR; trd = rx[0]; obs.push_back(rx); t_low = sel;
        end else if (sel && !trd) begin
          obs.push_back(rx); t_low = 1;
        end else t_low = 0;
      end else if (cnt == 9) begin
        cnt = 0; wasaddr = inaddr; inaddr = 0;
        if (sel && trd && (wasaddr || !mack) && txq.size() > 0) begin
          tx = txq.pop_front(); t_low = !tx[7];
        end else t_low = 0;
      end else if (cnt >= 1 && cnt <= 7 && sel && trd && !inaddr) begin
        t_low = !tx[7 - cnt];
      end
    end
    prv_scl = scl;
    prv_sda = sda;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdr(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      rdr(2'd0, v);
      if (!v[3]) break;
      @(negedge clk);
      n++;
      if (n > 50000) begin
        chk("R2 transfer-byte never cleared", 32'd1, 32'd0);
        break;
      end
    end
  endtask

  task automatic exp_byte(input string tag, input logic [7:0] b);
    if (obs.size() == 0) chk(tag, 32'hFFFF_FFFF, {24'd0, b});
    else chk(tag, {24'd0, obs.pop_front()}, {24'd0, b});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdr(2'd0, v); chk("R1 control after reset", v, 32'd0);
    rdr(2'd1, v); chk("R1 status after reset", v, 32'd0);
    chk("R1 line enables", {30'd0, scl_oe, sda_oe}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rdr(2'd3, v); chk("R13 monitor idle", v, 32'd3);

    // R12 command without unit enable is ignored
    wr(2'd0, TB | STA | 32'h2000);
    repeat (3 * QS) @(negedge clk);
    rdr(2'd0, v); chk("R12 tb without unit enable", {31'd0, v[3]}, 32'd0);
    chk("R12 SCL untouched", {31'd0, scl_oe}, 32'd0);
    // R12 refused byte without START while bus not held
    wr(2'd0, EN | TB);
    rdr(2'd0, v); chk("R12 refused tb", {31'd0, v[3]}, 32'd0);
    rdr(2'd1, v); chk("R12 refused sets bus error", {31'd0, v[22]}, 32'd1);
    wr(2'd1, 32'h0040_0000);
    rdr(2'd1, v); chk("R5 bus error cleared", v, 32'd0);

    // R2 R3 R9 address byte, write direction
    wr(2'd2, {24'd0, TADDR, 1'b0});
    wr(2'd0, EN | TXIE | TB | STA);
    wait_done(n);
    chk("R9 standard byte duration", n, 40 * QS);
    exp_byte("R2 address byte on bus", {TADDR, 1'b0});
    rdr(2'd1, v);
    chk("R3 tx empty", {31'd0, v[19]}, 32'd1);
    chk("R3 ack level", {31'd0, v[14]}, 32'd0);
    chk("R2 unit busy and bus busy", {30'd0, v[16], v[15]}, 32'd3);
    chk("R2 SCL held low", {31'd0, scl_oe}, 32'd1);
    chk("R5 irq from tx empty", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h0008_0000);
    rdr(2'd1, v); chk("R5 tx empty cleared", {31'd0, v[19]}, 32'd0);
    chk("R5 irq dropped", {31'd0, irq}, 32'd0);

    // R4 R8 data byte with STOP
    wr(2'd2, 32'h3C);
    wr(2'd0, EN | MSDE | MSDIE | TB | STO);
    wait_done(n);
    chk("R9 data byte with stop duration", n, 40 * QS);
    exp_byte("R4 data byte on bus", 8'h3C);
    rdr(2'd1, v);
    chk("R8 master stop flag", {31'd0, v[26]}, 32'd1);
    chk("R4 done flag", {31'd0, v[27]}, 32'd1);
    chk("R4 bus free", {30'd0, v[16], v[15]}, 32'd0);
    chk("R4 target saw stop", stops, 1);
    chk("R5 irq from master stop", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);
    rdr(2'd1, v); chk("R5 all flags cleared", v, 32'd0);

    // R8 no master-stop flag without its enable; R9 with stop
    wr(2'd2, {24'd0, TADDR, 1'b0});
    wr(2'd0, EN | TB | STA | STO);
    wait_done(n);
    chk("R9 start+stop byte duration", n, 44 * QS);
    exp_byte("R8 address byte", {TADDR, 1'b0});
    rdr(2'd1, v);
    chk("R8 master stop masked", {31'd0, v[26]}, 32'd0);
    chk("R8 done still set", {31'd0, v[27]}, 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);

    // R6 read two bytes
    txq.push_back(8'h96); txq.push_back(8'h5A);
    wr(2'd2, {24'd0, TADDR, 1'b1});
    wr(2'd0, EN | TB | STA);
    wait_done(n);
    exp_byte("R6 read address", {TADDR, 1'b1});
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, EN | TB);
    wait_done(n);
    rdr(2'd2, v); chk("R6 first read byte", v, 32'h96);
    rdr(2'd1, v); chk("R6 rx full", {31'd0, v[20]}, 32'd1);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, EN | TB | STO | NAK);
    wait_done(n);
    rdr(2'd2, v); chk("R6 second read byte", v, 32'h5A);
    chk("R6 acknowledge count", mackq.size(), 2);
    if (mackq.size() == 2) begin
      chk("R6 ack on first byte", {31'd0, mackq[0]}, 32'd0);
      chk("R6 nak on last byte", {31'd0, mackq[1]}, 32'd1);
    end
    chk("R6 stop after read", stops, 3);
    wr(2'd1, 32'hFFFF_FFFF);

    // R7 NAK on address
    wr(2'd2, 32'h44);
    wr(2'd0, EN | TB | STA);
    wait_done(n);
    exp_byte("R7 unanswered address", 8'h44);
    rdr(2'd1, v);
    chk("R7 bus error", {31'd0, v[22]}, 32'd1);
    chk("R7 nak level", {31'd0, v[14]}, 32'd1);
    chk("R7 stop generated", {30'd0, v[16], v[15]}, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF);

    // R9 fast mode
    wr(2'd2, {24'd0, TADDR, 1'b0});
    wr(2'd0, EN | FAST | TB | STA | STO);
    wait_done(n);
    chk("R9 fast byte duration", n, 44 * QF);
    exp_byte("R9 fast address byte", {TADDR, 1'b0});
    wr(2'd1, 32'hFFFF_FFFF);

    // R10 arbitration loss, R13 monitor
    force_arb = 1'b1;
    wr(2'd2, 32'hFE);
    wr(2'd0, EN | TB | STA);
    wait_done(n);
    rdr(2'd1, v);
    chk("R10 arbitration flag", {31'd0, v[18]}, 32'd1);
    chk("R10 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    chk("R13 early busy while SDA low", {31'd0, v[17]}, 32'd1);
    rdr(2'd3, v); chk("R13 monitor SDA low SCL high", v, 32'd2);
    force_arb = 1'b0;
    @(negedge clk); t_low = 1'b0;
    repeat (3) @(negedge clk);
    rdr(2'd3, v); chk("R13 monitor released", v, 32'd3);
    rdr(2'd1, v); chk("R13 bus busy gone after stop", {31'd0, v[16]}, 32'd0);

    // R11 unit reset
    wr(2'd0, EN | MSDE | URST);
    rdr(2'd0, v); chk("R11 control cleared", v, 32'd0);
    rdr(2'd1, v); chk("R11 status cleared", v, 32'd0);
    chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule